// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block receives a stereo serial audio stream as a slave. The bit clock, the frame (left/right) clock and the serial data all arrive asynchronously. They are brought into the system clock domain through a multi-flop synchronizer, and rising edges of the bit clock are detected there. Each channel has a 32-bit slot and each frame has 64 bit clocks. Within its slot, a channel's word is shifted in MSB first in two's complement.

A 2-bit format selector picks one of four framings. A force input overrides the selector and selects I2S framing. The framings differ in three ways: where the word sits inside the slot, how long it is, and which frame-clock level marks the left channel.

Once the right-channel word of a pair is complete, the block presents the left and right 20-bit words together and pulses a single valid strobe.

Top module: `aud_ser_rx`

## Requirements
- R1: `fmt_sel` selects the framing: 0 = 20-bit MSB-justified, 1 = 20-bit I2S, 2 = 20-bit LSB-justified, 3 = 16-bit LSB-justified.
- R2: While `force_i2s` is 1, `fmt_sel` has no effect and 20-bit I2S framing is used.
- R3: Data is sampled on rising edges of `bit_clk_in`, MSB first, with a 32-bit slot per channel. In both justified framings the left channel is the slot where `frame_clk_in` is 1. In I2S the left channel is the slot where `frame_clk_in` is 0.
- R4: Counting the first rising bit-clock edge after a frame-clock change as slot position 0, the MSB is taken at position 0 in MSB-justified framing and at position 1 in I2S framing. The following 19 positions carry the remaining bits.
- R5: In LSB-justified framings the last bit of the word is taken at slot position 31. The word therefore starts at position 12 for 20 bits and at position 16 for 16 bits. Data at slot positions outside the word has no effect on the output.
- R6: A 16-bit word is placed in bits 19..4 of its output, and bits 3..0 are zero.
- R7: Each completed right-channel word produces exactly one `pair_valid` pulse, one cycle wide. With it, the left word of the same frame and the new right word are presented together. Both outputs hold their values between pulses.
- R8: `pair_valid` rises exactly SYNC_STAGES+1 system clock cycles after the bit-clock rising edge that carries the last bit of the right word.
- R9: Reset clears both words and `pair_valid`. After reset, no word is captured until a frame-clock change has been seen between two bit-clock rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing selector |
| force_i2s | input | 1 | Forces 20-bit I2S framing when 1 |
| bit_clk_in | input | 1 | Serial bit clock, asynchronous |
| frame_clk_in | input | 1 | Left/right frame clock, asynchronous |
| data_in | input | 1 | Serial audio data |
| left_word | output | DATA_W | Left-channel sample |
| right_word | output | DATA_W | Right-channel sample |
| pair_valid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
The assertions take three things for granted about the inputs. Each bit-clock phase must last several system clock cycles. The frame clock and the data must change only while the bit clock is low. The framing selector and the force input must stay constant across a frame. Given these, every synchronized rising edge sees settled data and a settled frame level.

The stimulus keeps within these limits. It holds each bit-clock phase for four system cycles and drives the frame level and the data on falling system clock edges during the low phase. It changes the format only in the filler slot that precedes each frame.

// File: rtl/aud_rx_pkg.sv
`timescale 1ns/1ps
package aud_rx_pkg;
   typedef enum logic [1:0] {
      FMT_MSB_J  = 2'd0,
      FMT_I2S    = 2'd1,
      FMT_LSB_JL = 2'd2,
      FMT_LSB_JS = 2'd3
   } frame_fmt_e;
endpackage

// File: rtl/aud_rx_sync.sv
`timescale 1ns/1ps
module aud_rx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("aud_rx_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stage[0] <= '0;
      else        stage[0] <= async_in;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stage[i] <= '0;
         else        stage[i] <= stage[i-1];
      end
   end

   assign sync_out = stage[STAGES-1];
endmodule

// File: rtl/aud_rx_fmt_dec.sv
`timescale 1ns/1ps
module aud_rx_fmt_dec
   import aud_rx_pkg::*;
#(
   parameter int DATA_W  = 20,
   parameter int SHORT_W = 16,
   parameter int SLOT_W  = 32,
   parameter int CNT_W   = 6
) (
   input  logic [1:0]       fmt_sel,
   input  logic             force_i2s,
   output logic [CNT_W-1:0] first_pos,
   output logic [CNT_W-1:0] last_pos,
   output logic             short_word,
   output logic             left_level
);
   localparam logic [CNT_W-1:0] P_MSB_FIRST = '0;
   localparam logic [CNT_W-1:0] P_MSB_LAST  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] P_I2S_FIRST = CNT_W'(1);
   localparam logic [CNT_W-1:0] P_I2S_LAST  = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] P_LJL_FIRST = CNT_W'(SLOT_W - DATA_W);
   localparam logic [CNT_W-1:0] P_LJS_FIRST = CNT_W'(SLOT_W - SHORT_W);
   localparam logic [CNT_W-1:0] P_SLOT_LAST = CNT_W'(SLOT_W - 1);

   frame_fmt_e eff_fmt;

   always_comb begin
      eff_fmt = force_i2s ? FMT_I2S : frame_fmt_e'(fmt_sel);
      first_pos  = P_MSB_FIRST;
      last_pos   = P_MSB_LAST;
      short_word = 1'b0;
      left_level = 1'b1;
      unique case (eff_fmt)
         FMT_MSB_J: begin
            first_pos = P_MSB_FIRST;
            last_pos  = P_MSB_LAST;
         end
         FMT_I2S: begin
            first_pos  = P_I2S_FIRST;
            last_pos   = P_I2S_LAST;
            left_level = 1'b0;
         end
         FMT_LSB_JL: begin
            first_pos = P_LJL_FIRST;
            last_pos  = P_SLOT_LAST;
         end
         FMT_LSB_JS: begin
            first_pos  = P_LJS_FIRST;
            last_pos   = P_SLOT_LAST;
            short_word = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/aud_rx_slot.sv
`timescale 1ns/1ps
module aud_rx_slot #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_rise,
   input  logic             frame_lvl,
   output logic [CNT_W-1:0] cur_pos,
   output logic             bit_ok
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             seen;
   logic             lvl_prev;
   logic [CNT_W-1:0] pos_q;
   logic             slot_start;

   always_comb begin
      slot_start = seen && (frame_lvl != lvl_prev);
      if (slot_start)            cur_pos = '0;
      else if (pos_q == CNT_MAX) cur_pos = CNT_MAX;
      else                       cur_pos = pos_q + CNT_ONE;
      bit_ok = bit_rise && seen;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen     <= 1'b0;
         lvl_prev <= 1'b0;
         pos_q    <= CNT_MAX;
      end else if (bit_rise) begin
         seen     <= 1'b1;
         lvl_prev <= frame_lvl;
         pos_q    <= cur_pos;
      end
   end
endmodule

// File: rtl/aud_rx_deser.sv
`timescale 1ns/1ps
module aud_rx_deser #(
   parameter int DATA_W  = 20,
   parameter int SHORT_W = 16,
   parameter int CNT_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_ok,
   input  logic [CNT_W-1:0]  cur_pos,
   input  logic              sdata,
   input  logic              frame_lvl,
   input  logic [CNT_W-1:0]  first_pos,
   input  logic [CNT_W-1:0]  last_pos,
   input  logic              short_word,
   input  logic              left_level,
   output logic [DATA_W-1:0] left_word,
   output logic [DATA_W-1:0] right_word,
   output logic              pair_valid
);
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] left_hold;
   logic [DATA_W-1:0] next_bits;
   logic [DATA_W-1:0] word;
   logic              in_win;
   logic              word_done;

   assign next_bits = {shreg[DATA_W-2:0], sdata};
   assign in_win    = bit_ok && (cur_pos >= first_pos) && (cur_pos <= last_pos);
   assign word_done = in_win && (cur_pos == last_pos);

   if (SHORT_W < DATA_W) begin : g_pad
      assign word = short_word ? {next_bits[SHORT_W-1:0], {(DATA_W-SHORT_W){1'b0}}}
                               : next_bits;
   end else begin : g_nopad
      assign word = next_bits;
      logic unused_short;
      assign unused_short = short_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg      <= '0;
         left_hold  <= '0;
         left_word  <= '0;
         right_word <= '0;
         pair_valid <= 1'b0;
      end else begin
         pair_valid <= 1'b0;
         if (in_win) shreg <= next_bits;
         if (word_done) begin
            if (frame_lvl == left_level) begin
               left_hold <= word;
            end else begin
               left_word  <= left_hold;
               right_word <= word;
               pair_valid <= 1'b1;
            end
         end
      end
   end

   // R7: the strobe is a single cycle wide
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |=> !pair_valid);

   // R7: the outputs move only together with the strobe
   a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      ((left_word != $past(left_word)) || (right_word != $past(right_word))) |-> pair_valid);

   if (SHORT_W < DATA_W) begin : g_pad_chk
      // R6: a short word leaves its low bits clear
      a_r6_short_pad: assert property (@(posedge clk) disable iff (!rst_n)
         (pair_valid && $past(short_word)) |-> (right_word[DATA_W-SHORT_W-1:0] == '0));
   end
endmodule

// File: rtl/aud_ser_rx.sv
`timescale 1ns/1ps
module aud_ser_rx #(
   parameter int DATA_W      = 20,
   parameter int SHORT_W     = 16,
   parameter int SLOT_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        fmt_sel,
   input  logic              force_i2s,
   input  logic              bit_clk_in,
   input  logic              frame_clk_in,
   input  logic              data_in,
   output logic [DATA_W-1:0] left_word,
   output logic [DATA_W-1:0] right_word,
   output logic              pair_valid
);
   localparam int CNT_W = $clog2(SLOT_W) + 1;

   if (DATA_W + 1 > SLOT_W) begin : g_bad_slot
      $error("aud_ser_rx: slot too short for the word plus the I2S delay");
   end
   if (SHORT_W > DATA_W || SHORT_W < 2) begin : g_bad_short
      $error("aud_ser_rx: SHORT_W must lie in 2..DATA_W");
   end

   logic [2:0]       sync_bus;
   logic             bclk_s, frame_s, data_s, bclk_q, bit_rise;
   logic [CNT_W-1:0] cur_pos, first_pos, last_pos;
   logic             bit_ok, short_word, left_level;

   aud_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({bit_clk_in, frame_clk_in, data_in}),
      .sync_out (sync_bus)
   );
   assign {bclk_s, frame_s, data_s} = sync_bus;

   always_ff @(posedge clk) begin
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= bclk_s;
   end
   assign bit_rise = bclk_s && !bclk_q;

   aud_rx_fmt_dec #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_fmt (
      .fmt_sel    (fmt_sel),
      .force_i2s  (force_i2s),
      .first_pos  (first_pos),
      .last_pos   (last_pos),
      .short_word (short_word),
      .left_level (left_level)
   );

   aud_rx_slot #(.CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_rise  (bit_rise),
      .frame_lvl (frame_s),
      .cur_pos   (cur_pos),
      .bit_ok    (bit_ok)
   );

   aud_rx_deser #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)) u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_ok     (bit_ok),
      .cur_pos    (cur_pos),
      .sdata      (data_s),
      .frame_lvl  (frame_s),
      .first_pos  (first_pos),
      .last_pos   (last_pos),
      .short_word (short_word),
      .left_level (left_level),
      .left_word  (left_word),
      .right_word (right_word),
      .pair_valid (pair_valid)
   );

   // R8: a new pair follows a synchronized bit-clock rise by one cycle
   a_r8_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> $past(bit_rise));

   // R5: a pair is only produced at the last slot position of the word
   a_r5_end_position: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> ($past(cur_pos) == $past(last_pos)));
endmodule

// File: tb/aud_ser_rx_tb.sv
`timescale 1ns/1ps
module aud_ser_rx_tb;
   localparam int DW = 20;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    fmt_sel = 2'd0;
   logic          force_i2s = 1'b0;
   logic          bit_clk_in = 1'b0;
   logic          frame_clk_in = 1'b0;
   logic          data_in = 1'b0;
   logic [DW-1:0] left_word, right_word;
   logic          pair_valid;

   int n_checks = 0;
   int n_fail = 0;
   int vcount = 0;
   int lat = 0;
   logic [DW-1:0] cap_l = '0, cap_r = '0;

   always #2.5 clk = ~clk;

   aud_ser_rx #(.DATA_W(DW), .SHORT_W(16), .SLOT_W(32), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .force_i2s(force_i2s),
      .bit_clk_in(bit_clk_in), .frame_clk_in(frame_clk_in), .data_in(data_in),
      .left_word(left_word), .right_word(right_word), .pair_valid(pair_valid)
   );

   // {fmt_sel, force_i2s, left, right}
   localparam logic [42:0] VEC [0:9] = '{
      {2'd0, 1'b0, 20'h12345, 20'hABCDE},
      {2'd1, 1'b0, 20'h80000, 20'h7FFFF},
      {2'd2, 1'b0, 20'h00001, 20'hFFFFF},
      {2'd3, 1'b0, 20'h01234, 20'h0FEDC},
      {2'd0, 1'b1, 20'h55555, 20'hAAAAA},
      {2'd3, 1'b1, 20'h3C3C3, 20'hC3C3C},
      {2'd1, 1'b0, 20'h00000, 20'h80001},
      {2'd2, 1'b0, 20'hFEDCB, 20'h01234},
      {2'd3, 1'b0, 20'h08000, 20'h07FFF},
      {2'd0, 1'b0, 20'hFFFFF, 20'h00000}
   };

   always @(negedge clk) begin
      if (rst_n && pair_valid) begin
         vcount++;
         cap_l = left_word;
         cap_r = right_word;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic bit_val(input logic [1:0] eff, input logic [DW-1:0] w, input int b);
      int first, len;
      case (eff)
         2'd0: begin first = 0;  len = 20; end
         2'd1: begin first = 1;  len = 20; end
         2'd2: begin first = 12; len = 20; end
         default: begin first = 16; len = 16; end
      endcase
      if (b >= first && b < first + len) return w[len - 1 - (b - first)];
      return 1'b1;
   endfunction

   function automatic int last_pos(input logic [1:0] eff);
      case (eff)
         2'd0: return 19;
         2'd1: return 20;
         default: return 31;
      endcase
   endfunction

   task automatic send_bit(input logic lvl, input logic d, input logic track);
      @(negedge clk);
      frame_clk_in = lvl;
      data_in = d;
      repeat (3) @(negedge clk);
      bit_clk_in = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         if (track && lat == 0 && pair_valid) lat = k;
      end
      bit_clk_in = 1'b0;
   endtask

   task automatic send_frame(input logic [1:0] eff, input logic [DW-1:0] l, input logic [DW-1:0] r);
      logic left_lvl;
      left_lvl = (eff == 2'd1) ? 1'b0 : 1'b1;
      for (int b = 0; b < 32; b++) send_bit(~left_lvl, 1'b1, 1'b0);
      for (int b = 0; b < 32; b++) send_bit(left_lvl, bit_val(eff, l, b), 1'b0);
      lat = 0;
      for (int b = 0; b < 32; b++)
         send_bit(~left_lvl, bit_val(eff, r, b), (b == last_pos(eff)) ? 1'b1 : 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [1:0]    eff;
      logic [DW-1:0] el, er;
      int            base;
      repeat (5) @(negedge clk);
      // R9: reset state
      check("R9 reset left", 32'(left_word), 0);
      check("R9 reset right", 32'(right_word), 0);
      check("R9 reset valid", 32'(pair_valid), 0);
      rst_n = 1'b1;

      // R9: no frame-clock change, nothing captured
      fmt_sel = 2'd2;
      for (int b = 0; b < 64; b++) send_bit(1'b0, 1'b1, 1'b0);
      repeat (10) @(negedge clk);
      check("R9 no capture without frame edge", 32'(vcount), 0);
      check("R9 outputs untouched", 32'(right_word), 0);

      // R1..R8: vector table
      for (int i = 0; i < 10; i++) begin
         fmt_sel   = VEC[i][42:41];
         force_i2s = VEC[i][40];
         eff = VEC[i][40] ? 2'd1 : VEC[i][42:41];
         base = 0;
         send_frame(eff, VEC[i][39:20], VEC[i][19:0]);
         base = vcount;
         repeat (12) @(negedge clk);
         el = (eff == 2'd3) ? {VEC[i][35:20], 4'h0} : VEC[i][39:20];
         er = (eff == 2'd3) ? {VEC[i][15:0], 4'h0}  : VEC[i][19:0];
         // R1 R2 R3 R4 R5 R6: words decoded per framing
         check($sformatf("R1 R4 R5 R6 left vec%0d", i), 32'(cap_l), 32'(el));
         check($sformatf("R2 R3 R5 R6 right vec%0d", i), 32'(cap_r), 32'(er));
         // R7: outputs hold after the pulse
         check($sformatf("R7 hold vec%0d", i), 32'(right_word), 32'(er));
         // R8: strobe latency from the final bit edge
         check($sformatf("R8 latency vec%0d", i), 32'(lat), SYNC + 1);
         if (i == 0) check("R7 pulses so far", 32'(base), 1);
      end
      // R7: exactly one pulse per frame, plus filler slots that started a new slot
      check("R7 pulse count bound", 32'(vcount >= 10 && vcount <= 20), 1);

      // R9: reset mid-stream clears outputs
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 mid reset left", 32'(left_word), 0);
      check("R9 mid reset right", 32'(right_word), 0);
      check("R9 mid reset valid", 32'(pair_valid), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule